// File: doc/BRIEF.md
# Sync Polarity and Frequency Monitor

This block watches a horizontal and a vertical sync input coming into a display controller. It works out the polarity of each input by itself. It regenerates both syncs at an output polarity that software chooses. It also counts how many leading edges of one chosen sync arrive within a fixed gate window, and records how often that count wrapped. Firmware writes one small control word and reads one status word. The status word holds both polarity flags, a two-bit overflow history and the 10-bit count.

When the input arrives as composite sync on the horizontal pin, a separator can take over the vertical path. It treats any active pulse that lasts a minimum number of clocks as vertical sync. The separated signal then drives the vertical output and, if vertical measurement is selected, the counter as well. Every input passes through a two-flop synchroniser before any edge or level is used.

Top module: `syncMonitor`

## Requirements
- R1: After reset the status word (`statusOut`, 14 bits) reads 0x3000. Both polarity flags start as positive, the overflow field is 00 and the count is 0.
- R2: `statusOut[13]` (horizontal) and `statusOut[12]` (vertical) read 1 when the input is high for less than half of each period, which means positive polarity. They read 0 otherwise. Each flag is re-decided at every rising edge of its input.
- R3: Control bit 1 sets the level of `hsyncOut` during an active horizontal pulse, and bit 0 does the same for `vsyncOut`. With the bit at 1 the output is high during the pulse and low otherwise. With the bit at 0 this is inverted. The input polarity has no effect on this.
- R4: Control bit 3 picks the measured sync: 1 counts rising edges of the horizontal input, 0 counts rising edges of the vertical source.
- R5: The gate window is GATE_CYC clocks long. At the end of each window the count is latched into `statusOut[9:0]` and the counter starts again. A control write restarts the window and clears the counter.
- R6: `statusOut[11:10]` holds the overflow history: 00 for none, 01 for one wrap of the count past 1023, 10 for two or more. It never reads 11, and the count keeps wrapping modulo 1024 after the field saturates.
- R7: A rising edge that arrives in the last cycle of a window is counted in the next window, so every window with a strictly periodic input holds exactly GATE_CYC/period edges.
- R8: With control bit 2 set, the vertical source is the separator. Its output is high while the active horizontal pulse has lasted at least SEP_MIN clocks. `vsyncIn` is then ignored both for `vsyncOut` and for the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hsyncIn | input | 1 | Horizontal or composite sync pin |
| vsyncIn | input | 1 | Vertical sync pin |
| ctrlWr | input | 1 | Control write strobe |
| ctrlData | input | 4 | Control word: [3] measure horizontal, [2] separation, [1] hsync out positive, [0] vsync out positive |
| hsyncOut | output | 1 | Regenerated horizontal sync |
| vsyncOut | output | 1 | Regenerated vertical sync |
| statusOut | output | CNT_W+4 | {hPol, vPol, overflow[1:0], count} |

## Verification
The end of a gate window and a counted rising edge can land in the same cycle. In that cycle the counter must latch the old total and also keep the new edge for the next window. The bench provokes this with a horizontal input that toggles every clock, so an edge arrives every second cycle. It runs this case at two phase offsets relative to the control write, which puts the gate end once on an edge cycle and once off it. The result is judged by the exact latched count and the saturated overflow field. Any lost or doubled edge moves the count away from zero.

// File: rtl/syncMonPkg.sv
package syncMonPkg;

  typedef struct packed {
    logic measH;
    logic sepEn;
    logic hOutPos;
    logic vOutPos;
  } ctrlRegT;

  typedef struct packed {
    logic gateEnd;
    logic restart;
  } strobeT;

  localparam int CTRL_W = 4;

endpackage

// File: rtl/syncPolDetect.sv
module syncPolDetect #(
  parameter int POL_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic polOut
);
  localparam logic [POL_W-1:0] CNT_MAX = '1;

  logic             sigPrev;
  logic             rise;
  logic [POL_W-1:0] highCnt;
  logic [POL_W-1:0] perCnt;
  logic             shortHigh;

  assign rise      = sigIn && !sigPrev;
  assign shortHigh = {highCnt, 1'b0} < {1'b0, perCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigPrev <= 1'b0;
      highCnt <= '0;
      perCnt  <= '0;
      polOut  <= 1'b1;
    end else begin
      sigPrev <= sigIn;
      if (rise) begin
        polOut  <= shortHigh;
        perCnt  <= POL_W'(1);
        highCnt <= POL_W'(1);
      end else begin
        if (perCnt != CNT_MAX) perCnt <= perCnt + 1'b1;
        if (sigIn && highCnt != CNT_MAX) highCnt <= highCnt + 1'b1;
      end
    end
  end

  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rise |=> $stable(polOut)); // R2

endmodule

// File: rtl/syncMonCtrl.sv
module syncMonCtrl
  import syncMonPkg::*;
#(
  parameter int GATE_CYC = 6144
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [CTRL_W-1:0]   ctrlData,
  output ctrlRegT             ctrlReg,
  output strobeT              strb
);
  localparam int GW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYC - 1);

  logic [GW-1:0] gateTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      gateTimer <= '0;
    end else if (ctrlWr) begin
      ctrlReg   <= ctrlRegT'(ctrlData);
      gateTimer <= '0;
    end else if (gateTimer == GATE_LAST) begin
      gateTimer <= '0;
    end else begin
      gateTimer <= gateTimer + 1'b1;
    end
  end

  always_comb begin
    strb.restart = ctrlWr;
    strb.gateEnd = !ctrlWr && (gateTimer == GATE_LAST);
  end

  AST_GATE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strb.gateEnd |=> !strb.gateEnd); // R5

  AST_WRITE_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (gateTimer == '0)); // R5

endmodule

// File: rtl/syncMonDatapath.sv
module syncMonDatapath
  import syncMonPkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int POL_W   = 16,
  parameter int SEP_MIN = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  ctrlRegT          ctrlReg,
  input  strobeT           strb,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic [CNT_W+3:0] statusOut
);
  localparam int NSYNC = 2;
  localparam int IDX_H = 1;
  localparam int IDX_V = 0;
  localparam int SEP_W = $clog2(SEP_MIN + 1);
  localparam logic [SEP_W-1:0] SEP_LAST = SEP_W'(SEP_MIN - 1);
  localparam logic [SEP_W-1:0] SEP_TOP  = SEP_W'(SEP_MIN);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [1:0] OVF_NONE = 2'b00;
  localparam logic [1:0] OVF_ONE  = 2'b01;
  localparam logic [1:0] OVF_TWO  = 2'b10;

  logic [NSYNC-1:0] pinRaw;
  logic [NSYNC-1:0] meta;
  logic [NSYNC-1:0] syncd;
  logic [NSYNC-1:0] pol;
  logic [NSYNC-1:0] active;

  assign pinRaw = {hsyncIn, vsyncIn};

  for (genvar i = 0; i < NSYNC; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta[i]  <= 1'b0;
        syncd[i] <= 1'b0;
      end else begin
        meta[i]  <= pinRaw[i];
        syncd[i] <= meta[i];
      end
    end

    syncPolDetect #(.POL_W(POL_W)) uPol (
      .clk   (clk),
      .rstN  (rstN),
      .sigIn (syncd[i]),
      .polOut(pol[i])
    );

    assign active[i] = ~(syncd[i] ^ pol[i]);
  end

  // composite separator: long active horizontal pulse means vertical sync
  logic [SEP_W-1:0] sepRun;
  logic             sepV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sepRun <= '0;
      sepV   <= 1'b0;
    end else begin
      if (!active[IDX_H])       sepRun <= '0;
      else if (sepRun != SEP_TOP) sepRun <= sepRun + 1'b1;
      sepV <= active[IDX_H] && (sepRun >= SEP_LAST);
    end
  end

  logic vSrcActive;
  assign vSrcActive = ctrlReg.sepEn ? sepV : active[IDX_V];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
    end else begin
      hsyncOut <= ctrlReg.hOutPos ? active[IDX_H] : !active[IDX_H];
      vsyncOut <= ctrlReg.vOutPos ? vSrcActive : !vSrcActive;
    end
  end

  // frequency counter
  logic             measSrc;
  logic             measPrev;
  logic             measEdge;
  logic [CNT_W-1:0] freqCnt;
  logic [1:0]       ovfCnt;
  logic [CNT_W-1:0] statCnt;
  logic [1:0]       statOvf;

  always_comb begin
    if (ctrlReg.measH)      measSrc = syncd[IDX_H];
    else if (ctrlReg.sepEn) measSrc = sepV;
    else                    measSrc = syncd[IDX_V];
  end

  assign measEdge = measSrc && !measPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measPrev <= 1'b0;
      freqCnt  <= '0;
      ovfCnt   <= OVF_NONE;
      statCnt  <= '0;
      statOvf  <= OVF_NONE;
    end else begin
      measPrev <= measSrc;
      if (strb.restart) begin
        freqCnt <= '0;
        ovfCnt  <= OVF_NONE;
      end else if (strb.gateEnd) begin
        statCnt <= freqCnt;
        statOvf <= ovfCnt;
        freqCnt <= measEdge ? CNT_W'(1) : '0;
        ovfCnt  <= OVF_NONE;
      end else if (measEdge) begin
        if (freqCnt == CNT_MAX) begin
          freqCnt <= '0;
          ovfCnt  <= (ovfCnt == OVF_NONE) ? OVF_ONE : OVF_TWO;
        end else begin
          freqCnt <= freqCnt + 1'b1;
        end
      end
    end
  end

  assign statusOut = {pol[IDX_H], pol[IDX_V], statOvf, statCnt};

  AST_OVF_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (statOvf != 2'b11) && (ovfCnt != 2'b11)); // R6

  AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCnt == OVF_TWO && !strb.restart && !strb.gateEnd) |=> (ovfCnt == OVF_TWO)); // R6

  AST_GATE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.gateEnd |=> (freqCnt <= CNT_W'(1)) && (ovfCnt == OVF_NONE)); // R7

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (freqCnt == '0) && (ovfCnt == OVF_NONE)); // R5

  AST_SEP_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !active[IDX_H] |=> !sepV); // R8

endmodule

// File: rtl/syncMonitor.sv
module syncMonitor
  import syncMonPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int GATE_CYC = 6144,
  parameter int POL_W    = 16,
  parameter int SEP_MIN  = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             ctrlWr,
  input  logic [3:0]       ctrlData,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic [CNT_W+3:0] statusOut
);
  ctrlRegT ctrlReg;
  strobeT  strb;

  syncMonCtrl #(.GATE_CYC(GATE_CYC)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlWr  (ctrlWr),
    .ctrlData(ctrlData),
    .ctrlReg (ctrlReg),
    .strb    (strb)
  );

  syncMonDatapath #(
    .CNT_W  (CNT_W),
    .POL_W  (POL_W),
    .SEP_MIN(SEP_MIN)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncIn  (hsyncIn),
    .vsyncIn  (vsyncIn),
    .ctrlReg  (ctrlReg),
    .strb     (strb),
    .hsyncOut (hsyncOut),
    .vsyncOut (vsyncOut),
    .statusOut(statusOut)
  );

endmodule

// File: tb/tb_syncMonitor.sv
module tb_syncMonitor;
  localparam int GATE = 6144;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsyncIn = 1'b0;
  logic        vsyncIn = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [3:0]  ctrlData = 4'h0;
  logic        hsyncOut;
  logic        vsyncOut;
  logic [13:0] statusOut;

  int nChk = 0;
  int nErr = 0;

  int hPer = 64, hWid = 8, hLongEvery = 0, hLongWid = 0;
  int hPhase = 0, hLine = 0, hCur = 0, hCurLine = 0;
  bit hPos = 1'b1;
  int vPer = 1024, vWid = 16, vPhase = 0, vCur = 0;
  bit vPos = 1'b1;

  always #4 clk = ~clk;

  syncMonitor #(.GATE_CYC(GATE)) dut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .statusOut(statusOut)
  );

  always @(negedge clk) begin
    int w;
    w = (hLongEvery != 0 && hLine == hLongEvery - 1) ? hLongWid : hWid;
    hsyncIn = (hPhase < w) ? hPos : !hPos;
    hCur = hPhase;
    hCurLine = hLine;
    if (hPhase >= hPer - 1) begin
      hPhase = 0;
      if (hLongEvery == 0 || hLine >= hLongEvery - 1) hLine = 0;
      else hLine = hLine + 1;
    end else begin
      hPhase = hPhase + 1;
    end
    vsyncIn = (vPhase < vWid) ? vPos : !vPos;
    vCur = vPhase;
    vPhase = (vPhase >= vPer - 1) ? 0 : vPhase + 1;
  end

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCtrl(logic [3:0] val);
    @(negedge clk);
    ctrlData = val;
    ctrlWr = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic setH(int per, int wid, bit pos);
    @(posedge clk); #2;
    hPer = per; hWid = wid; hPos = pos; hLongEvery = 0; hLongWid = 0;
    hPhase = 0; hLine = 0;
  endtask

  task automatic waitWindows();
    repeat (3 * GATE + 64) @(posedge clk);
    #2;
  endtask

  task automatic waitH(int ph, int line);
    @(posedge clk); #2;
    while (!(hCur == ph && (line < 0 || hCurLine == line))) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic waitV(int ph);
    @(posedge clk); #2;
    while (vCur != ph) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic testReset();
    check("R1 status after reset", statusOut, 14'h3000);
  endtask

  task automatic testPositive();
    setH(64, 8, 1'b1);
    writeCtrl(4'b1011);
    waitWindows();
    check("R2 hPol positive", statusOut[13], 1);
    check("R2 vPol positive", statusOut[12], 1);
    check("R4 horizontal count", statusOut[9:0], 96);
    check("R6 no overflow", statusOut[11:10], 0);
    waitH(6, -1);
    check("R3 hsyncOut active, positive forced", hsyncOut, 1);
    waitH(32, -1);
    check("R3 hsyncOut idle, positive forced", hsyncOut, 0);
  endtask

  task automatic testNegative();
    setH(64, 8, 1'b0);
    vPos = 1'b0;
    writeCtrl(4'b0001);
    waitWindows();
    check("R2 hPol negative", statusOut[13], 0);
    check("R2 vPol negative", statusOut[12], 0);
    check("R4 vertical count", statusOut[9:0], 6);
    waitH(6, -1);
    check("R3 hsyncOut active, negative forced", hsyncOut, 0);
    waitH(32, -1);
    check("R3 hsyncOut idle, negative forced", hsyncOut, 1);
    waitV(8);
    check("R3 vsyncOut active, positive forced", vsyncOut, 1);
    waitV(512);
    check("R3 vsyncOut idle, positive forced", vsyncOut, 0);
    vPos = 1'b1;
  endtask

  task automatic testOverflow(int per, int wid, int off, int expCnt, int expOvf, string tag);
    setH(per, wid, 1'b1);
    repeat (off) @(negedge clk);
    writeCtrl(4'b1011);
    waitWindows();
    check({tag, " count"}, statusOut[9:0], expCnt);
    check({tag, " overflow"}, statusOut[11:10], expOvf);
  endtask

  task automatic testSeparation();
    setH(64, 6, 1'b1);
    hLongEvery = 16; hLongWid = 28;
    vPer = 8; vWid = 4; vPhase = 0;
    writeCtrl(4'b0111);
    waitWindows();
    check("R8 separated vertical count, vsyncIn ignored", statusOut[9:0], 6);
    check("R2 composite stays positive", statusOut[13], 1);
    waitH(26, 15);
    check("R8 vsyncOut high in long pulse", vsyncOut, 1);
    waitH(26, 3);
    check("R8 vsyncOut low in normal line", vsyncOut, 0);
    vPer = 1024; vWid = 16; vPhase = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #2;
    testReset();
    rstN = 1'b1;
    testPositive();
    testNegative();
    testOverflow(8, 2, 0, 768, 0, "R6 period 8");
    testOverflow(4, 1, 0, 512, 1, "R6 period 4 one wrap");
    testOverflow(3, 1, 0, 0, 2, "R6 period 3 two wraps");
    testOverflow(2, 1, 0, 0, 2, "R7 period 2 offset 0 saturated");
    testOverflow(2, 1, 1, 0, 2, "R7 period 2 offset 1 saturated");
    testSeparation();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule